// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block takes 32 level-sensitive interrupt request lines and masks each one with its own enable bit. It raises a single interrupt request to the processor, and a vector byte names the highest-priority line that is both asserted and enabled. Priority is hardwired: the line with the larger index always wins. The vector is 10h plus the index of the winning line. Line 0 has no source wired to it, so the code 10h also serves as the "spurious" answer. The processor gets that answer when the request it was servicing has gone away before it reads the vector.

Software reaches the block through a small word-wide register bus. The bus gives access to two enable words, two read-only words that show the raw request levels, and a read-only vector word. The processor reads the vector word during its acknowledge cycle. The value returned is taken into a holding register on the read, so it cannot change within that bus cycle. The processor's global interrupt enable is an input, and it gates the outgoing request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all enable bits are 0, `int_o` is low, and a read of the vector word (offset 00h) returns 0010h.
- R2: The enable word at offset 0Eh holds the enables for lines 0..15, with bit i for line i. The enable word at offset 10h holds lines 16..31, with bit i for line 16+i. A write stores the value and a read returns it.
- R3: The status word at offset 0Ah shows the sampled levels of lines 0..15, and the word at 0Ch shows lines 16..31, in the same bit order as R2. The enable bits do not affect these words.
- R4: A read of offset 00h returns 0010h + n in bits 7:0, with the upper bits 0. Here n is the highest-numbered line that is both asserted and enabled. Line 31 beats every other line, and line 0 loses to every other line.
- R5: An asserted line whose enable bit is 0 affects neither the vector nor `int_o`.
- R6: `int_o` is high exactly when `gie_i` is high and at least one enabled line was asserted at the previous rising clock edge.
- R7: Requests are levels. A line that is released stops counting one edge later. When no enabled line is asserted, the vector read returns 0010h.
- R8: Writes to offsets 00h, 0Ah, 0Ch and to any unmapped offset change nothing. Reads of unmapped offsets return 0000h.
- R9: Read data appears on `rdata_o` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | 32 | Level interrupt request lines |
| gie_i | input | 1 | Global maskable-interrupt enable from the processor |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The request lines are sampled at one edge, so a change on `irq_i` first shows in status, vector and `int_o` after the next rising edge. The bench changes the lines at a falling edge and waits one full cycle before it checks `int_o` or issues a read. A read or write is presented at a falling edge and takes effect at the following rising edge. The bench therefore samples `rdata_o` at the next falling edge, and it reads an enable word back only after the write's edge has passed. The same fixed timing covers the drop-before-acknowledge case: a line is released one cycle before the vector read, and the read must then give 0010h.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    // Register offsets (byte addresses on the local bus)
    localparam int unsigned OFF_VECTOR    = 'h00;
    localparam int unsigned OFF_STAT_BASE = 'h0A;
    localparam int unsigned OFF_EN_BASE   = 'h0E;
    localparam int unsigned OFF_STRIDE    = 2;

    // Vector code of line 0, also the spurious code
    localparam int unsigned VEC_BASE      = 'h10;
    localparam int unsigned VEC_W         = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_EN   = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/ivc_pend_sample.sv
module ivc_pend_sample #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    output logic [NUM_IRQ-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

`ifndef SYNTHESIS
    // R7: a level is followed edge by edge, so a released line leaves one edge later
    a_r7_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (pend_o == $past(irq_i)));
`endif

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int unsigned NUM_IRQ = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] req_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from low to high so the last hit (highest index) wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 5,
    localparam int unsigned NBANK  = NUM_IRQ / DATA_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [VEC_W-1:0]   vec_i,
    output logic [NUM_IRQ-1:0] en_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [NBANK-1:0][DATA_W-1:0] en;
        logic [DATA_W-1:0]            rdata;
    } state_t;

    state_t              st_d, st_q;
    rd_sel_e             sel;
    logic [$clog2(NBANK+1)-1:0] bank;
    logic                wr_en_hit;

    // Address decode
    always_comb begin
        sel       = SEL_NONE;
        bank      = '0;
        wr_en_hit = 1'b0;
        if (addr_i == ADDR_W'(OFF_VECTOR)) begin
            sel = SEL_VEC;
        end
        for (int k = 0; k < int'(NBANK); k++) begin
            if (addr_i == ADDR_W'(OFF_STAT_BASE + OFF_STRIDE * k)) begin
                sel  = SEL_STAT;
                bank = $bits(bank)'(k);
            end
            if (addr_i == ADDR_W'(OFF_EN_BASE + OFF_STRIDE * k)) begin
                sel       = SEL_EN;
                bank      = $bits(bank)'(k);
                wr_en_hit = 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (req_i && we_i && wr_en_hit) begin
            st_d.en[bank] = wdata_i;
        end
        if (req_i && !we_i) begin
            unique case (sel)
                SEL_VEC:  st_d.rdata = DATA_W'(vec_i);
                SEL_STAT: st_d.rdata = pend_i[bank*DATA_W +: DATA_W];
                SEL_EN:   st_d.rdata = st_q.en[bank];
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign rdata_o = st_q.rdata;

`ifndef SYNTHESIS
    // R8: enables move only on a write that decodes to an enable word
    a_r8_enable_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && we_i && wr_en_hit) |=> $stable(en_o));
    // R9: read data holds between reads
    a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && !we_i) |=> $stable(rdata_o));
    // R4: a vector read always returns a code in 10h..2Fh
    a_r4_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && sel == SEL_VEC) |=>
            (rdata_o >= DATA_W'(VEC_BASE) && rdata_o < DATA_W'(VEC_BASE + NUM_IRQ)));
`endif

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 5,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               gie_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               int_o
);

    logic [NUM_IRQ-1:0] pend;
    logic [NUM_IRQ-1:0] en;
    logic [NUM_IRQ-1:0] live;
    logic               found;
    logic [IDX_W-1:0]   idx;
    logic [VEC_W-1:0]   vec;

    ivc_pend_sample #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i),
        .pend_o (pend)
    );

    assign live = pend & en;

    ivc_prio_enc #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .req_i   (live),
        .found_o (found),
        .idx_o   (idx)
    );

    // Line 0 and "nothing pending" share the base code
    assign vec = found ? VEC_W'(VEC_BASE + int'(idx)) : VEC_W'(VEC_BASE);

    ivc_regfile #(
        .NUM_IRQ (NUM_IRQ),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_i),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend),
        .vec_i   (vec),
        .en_o    (en),
        .rdata_o (rdata_o)
    );

    assign int_o = gie_i & found;

`ifndef SYNTHESIS
    // R6: no request to the processor while globally disabled
    a_r6_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |-> gie_i);
    // R5: the winner is a line that is both pending and enabled
    a_r5_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        found |-> (pend[idx] && en[idx]));
    // R4: no enabled pending line sits above the winner
    a_r4_no_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
        found |-> ((live >> idx) == NUM_IRQ'(1)));
    // R7: with nothing live, the encoder reports no winner
    a_r7_idle_no_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live == '0) |-> !int_o);
`endif

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        gie = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        intr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] en_m = '0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .irq_i   (irq),
        .gie_i   (gie),
        .req_i   (req),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .int_o   (intr)
    );

    function automatic logic [15:0] exp_vec(logic [31:0] p, logic [31:0] e);
        for (int i = 31; i >= 0; i--) begin
            if (p[i] && e[i]) return 16'(16 + i);
        end
        return 16'h0010;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic set_irq(logic [31:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
    endtask

    task automatic set_en(logic [31:0] v);
        wr(5'h0E, v[15:0]);
        wr(5'h10, v[31:16]);
        en_m = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] d2;
        int unsigned seed;
        seed = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_o after reset", 32'(intr), 0);
        rd(5'h0E, d); check("R1 enable0 reset", 32'(d), 0);
        rd(5'h10, d); check("R1 enable1 reset", 32'(d), 0);
        rd(5'h00, d); check("R1 vector reset", 32'(d), 32'h10);

        // R2 write / readback
        wr(5'h0E, 16'hA5C3); wr(5'h10, 16'h3C5A);
        rd(5'h0E, d); check("R2 enable0 readback", 32'(d), 32'hA5C3);
        rd(5'h10, d); check("R2 enable1 readback", 32'(d), 32'h3C5A);
        en_m = 32'h3C5A_A5C3;

        // R3 status independent of enables
        set_en(32'h0);
        set_irq(32'h8001_4002);
        rd(5'h0A, d); check("R3 status0 raw", 32'(d), 32'h4002);
        rd(5'h0C, d); check("R3 status1 raw", 32'(d), 32'h8001);

        // R5 disabled lines ignored
        gie = 1'b1;
        @(negedge clk);
        check("R5 int_o with all disabled", 32'(intr), 0);
        rd(5'h00, d); check("R5 vector with all disabled", 32'(d), 32'h10);

        // R4 line 31 beats all
        set_en(32'hFFFF_FFFF);
        set_irq(32'hFFFF_FFFF);
        rd(5'h00, d); check("R4 line31 wins", 32'(d), 32'h2F);
        check("R6 int_o all live", 32'(intr), 1);
        set_irq(32'h0000_0001);
        rd(5'h00, d); check("R4 line0 alone", 32'(d), 32'h10);
        set_irq(32'h0001_0001);
        rd(5'h00, d); check("R4 line16 beats line0", 32'(d), 32'h20);

        // R6 global gate
        gie = 1'b0;
        @(negedge clk);
        check("R6 int_o gated by gie", 32'(intr), 0);
        gie = 1'b1;
        @(negedge clk);
        check("R6 int_o with gie", 32'(intr), 1);

        // R7 drop before acknowledge
        set_en(32'h0000_0100);
        set_irq(32'h0000_0100);
        check("R7 int_o while held", 32'(intr), 1);
        set_irq(32'h0);
        check("R7 int_o after release", 32'(intr), 0);
        rd(5'h00, d); check("R7 spurious vector", 32'(d), 32'h10);

        // R8 writes to read-only and unmapped offsets
        set_irq(32'h0000_0100);
        wr(5'h00, 16'hFFFF); wr(5'h0A, 16'hFFFF); wr(5'h0C, 16'hFFFF);
        wr(5'h04, 16'hFFFF); wr(5'h1E, 16'hFFFF);
        rd(5'h0E, d); check("R8 enable0 untouched", 32'(d), 32'h0100);
        rd(5'h10, d); check("R8 enable1 untouched", 32'(d), 32'h0);
        rd(5'h0A, d); check("R8 status0 read-only", 32'(d), 32'h0100);
        rd(5'h00, d); check("R8 vector read-only", 32'(d), 32'h18);
        rd(5'h04, d); check("R8 unmapped read", 32'(d), 32'h0);

        // R9 hold until next read
        rd(5'h00, d);
        set_irq(32'h0);
        wr(5'h0E, 16'h0);
        repeat (3) @(negedge clk);
        check("R9 rdata holds", 32'(rdata), 32'h18);
        en_m = 32'h0;

        // Random traffic
        for (int it = 0; it < 300; it++) begin
            logic [31:0] v;
            v = $urandom & $urandom;
            if ($urandom_range(0, 3) == 0) set_en($urandom);
            gie = 1'($urandom_range(0, 1));
            set_irq(v);
            check("R6 random int_o", 32'(intr),
                  32'(gie && ((v & en_m) != 0)));
            rd(5'h00, d);
            check("R4 random vector", 32'(d), 32'(exp_vec(v, en_m)));
            rd(($urandom_range(0, 1) != 0) ? 5'h0C : 5'h0A, d2);
            check("R3 random status", 32'(d2),
                  32'((addr == 5'h0C) ? v[31:16] : v[15:0]));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule